// File: doc/BRIEF.md
# SPI Burst Transmit Master

This block is the transmit side of an SPI master. Software-facing logic pushes 32-bit words into a 64-entry transmit queue. The engine turns those words into serial bursts on SCLK/MOSI with an active-low chip select. The burst length is a programmable bit count from 1 to 4096. A burst longer than one word takes its bits from several consecutive queue words.

Two configuration bits select how transfers are framed. The start-mode bit picks between waiting for a software exchange strobe and starting on its own as soon as the queue holds data. The waveform bit picks between one held burst per exchange and a run of separate bursts that drains the queue, with chip select released between bursts.

SCLK is derived from the system clock by a programmable divider, with selectable idle polarity and sampling phase. A level interrupt reports that the queue is empty and no burst is in flight.

Top module: `spi_burst_master`

## Requirements
- R1: The length field holds the burst bit count minus one; a burst produces exactly field+1 sampling edges while chip select (`ss_n`) is low.
- R2: Lengths up to 4096 bits are supported in a single burst, drawing 128 words from the queue while it is refilled.
- R3: Within a burst, the first word popped supplies (length mod 32) bits taken from its least-significant end, or 32 bits when the length is a multiple of 32. Every later word supplies all 32 bits. Each word is sent most-significant valid bit first.
- R4: With `cfg_multi`=1 and `cfg_auto`=0, one exchange sends back-to-back bursts of the configured length with `ss_n` high between them, until the queue is empty; `xch` then returns to 0.
- R5: With `cfg_multi`=0 and `cfg_auto`=0, one exchange sends exactly one burst and `xch` returns to 0 as `ss_n` rises. Words left in the queue are not sent until the next exchange.
- R6: With `cfg_auto`=0, no burst starts while `xch` is 0, even with data queued.
- R7: With `cfg_auto`=1, bursts start whenever the queue holds data, without any strobe, and `cfg_multi` is ignored (each burst is separate).
- R8: `tx_done_irq` is 1 exactly when the queue is empty and no burst is active; it is 0 while words remain queued.
- R9: SCLK rests at `cfg_cpol` whenever chip select is released. With `cfg_cpha`=0, data is sampled on the first (leading) edge of each bit; with `cfg_cpha`=1, on the second (trailing) edge.
- R10: Each SCLK half period lasts `cfg_div`+1 system clock cycles.
- R11: `busy` is 1 from chip-select assertion to chip-select release.
- R12: The queue holds 64 words. A write while it is full is dropped and sets the sticky `ovf` flag.
- R13: If the queue runs dry in the middle of a multi-word burst, chip select stays low and SCLK stops toggling until the next word arrives; the burst then resumes without losing bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 12 | Burst length in bits minus one |
| cfg_multi | input | 1 | 1: per-burst chip-select pulses until the queue drains; 0: one burst per exchange |
| cfg_auto | input | 1 | 1: start bursts whenever data is queued |
| cfg_div | input | 8 | SCLK half period minus one, in system clocks |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| xch_set | input | 1 | One-cycle strobe that sets the exchange bit |
| xch | output | 1 | Exchange bit; clears itself when the exchange is finished |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Queue write data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low chip select |
| busy | output | 1 | A burst is in flight |
| tx_done_irq | output | 1 | Queue empty and engine idle |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
The hardest state to reach from the ports is a queue that runs empty halfway through a multi-word burst. The bench reaches it on purpose by queuing only the first of two words for a 64-bit burst. It then waits far longer than 32 bit times and confirms that chip select is held low and SCLK is frozen before it supplies the second word. The 4096-bit case is reached by trickling 64 words into the queue while the burst is already draining it. The overflow case is reached by loading 65 words with no exchange pending and then sending a 2048-bit burst, which shows that the 65th word never entered the queue.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } eng_state_e;

endpackage

// File: rtl/spi_txq.sv
`timescale 1ns/1ps
module spi_txq #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic              ovf
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("spi_txq: DEPTH must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp, wp_nx, rp_nx;
   logic [CW-1:0]     cnt;
   logic              ovf_q;
   logic              do_wr, do_rd;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_wr   = wr_en && !full;
   assign do_rd   = rd_en && !empty;
   assign rd_data = mem[rp];
   assign ovf     = ovf_q;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wp_nx = wp + AW'(1);
         assign rp_nx = rp + AW'(1);
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         cnt   <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (do_wr) wp <= wp_nx;
         if (do_rd) rp <= rp_nx;
         if (do_wr && !do_rd)      cnt <= cnt + CW'(1);
         else if (do_rd && !do_wr) cnt <= cnt - CW'(1);
         if (wr_en && full) ovf_q <= 1'b1;
      end
   end

   // R12
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> (full && ovf));

   // R12
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

endmodule

// File: rtl/spi_clkdiv.sv
`timescale 1ns/1ps
module spi_clkdiv #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = en && (cnt == div);

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (!en || tick) cnt <= '0;
      else                  cnt <= cnt + DIV_W'(1);
   end

   // R10
   div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/spi_burst_eng.sv
`timescale 1ns/1ps
module spi_burst_eng
   import spi_burst_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_multi,
   input  logic              cfg_auto,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              xch_set,
   input  logic              tick,
   input  logic [WORD_W-1:0] q_data,
   input  logic              q_empty,
   output logic              q_pop,
   output logic              run_en,
   output logic              sclk,
   output logic              mosi,
   output logic              ss_n,
   output logic              busy,
   output logic              xch
);
   localparam int unsigned SH_W = $clog2(WORD_W);
   localparam int unsigned WB_W = SH_W + 1;
   localparam int unsigned BL_W = LEN_W + 1;

   eng_state_e        st;
   logic [WORD_W-1:0] sh;
   logic [BL_W-1:0]   bits_left;
   logic [WB_W-1:0]   wbits;
   logic              ph, first, sclk_q, ss_q, xch_q;

   logic [BL_W-1:0]   len_total;
   logic [SH_W-1:0]   rem;
   logic [WB_W-1:0]   first_bits;
   logic [WORD_W-1:0] first_word;
   logic              go, lead, adv, need_word, stall, fin;

   always_comb begin
      len_total  = BL_W'(cfg_len) + BL_W'(1);
      rem        = len_total[SH_W-1:0];
      first_bits = (rem == '0) ? WB_W'(WORD_W) : WB_W'(rem);
      first_word = q_data << (WB_W'(WORD_W) - first_bits);
      go         = !q_empty && (cfg_auto || xch_q);
      lead       = !ph;
      adv        = lead ? (cfg_cpha && !first && bits_left != '0)
                        : (!cfg_cpha && bits_left > BL_W'(1));
      need_word  = adv && (wbits == WB_W'(1));
      stall      = need_word && q_empty;
      fin        = lead && (bits_left == '0);
   end

   assign q_pop  = ((st == ST_IDLE) && go) ||
                   ((st == ST_RUN) && tick && !fin && need_word && !q_empty);
   assign run_en = (st != ST_IDLE);
   assign sclk   = sclk_q;
   assign ss_n   = ss_q;
   assign mosi   = !ss_q && sh[WORD_W-1];
   assign busy   = (st == ST_RUN);
   assign xch    = xch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sh        <= '0;
         bits_left <= '0;
         wbits     <= '0;
         ph        <= 1'b0;
         first     <= 1'b0;
         sclk_q    <= 1'b0;
         ss_q      <= 1'b1;
         xch_q     <= 1'b0;
      end else begin
         if (xch_set) xch_q <= 1'b1;
         unique case (st)
            ST_IDLE: begin
               sclk_q <= cfg_cpol;
               if (go) begin
                  st        <= ST_RUN;
                  ss_q      <= 1'b0;
                  sh        <= first_word;
                  wbits     <= first_bits;
                  bits_left <= len_total;
                  ph        <= 1'b0;
                  first     <= 1'b1;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  if (fin) begin
                     st   <= ST_GAP;
                     ss_q <= 1'b1;
                     if (!cfg_multi || q_empty) xch_q <= 1'b0;
                  end else if (!stall) begin
                     sclk_q <= ~sclk_q;
                     ph     <= ~ph;
                     if (lead) first <= 1'b0;
                     else      bits_left <= bits_left - BL_W'(1);
                     if (adv) begin
                        if (need_word) begin
                           sh    <= q_data;
                           wbits <= WB_W'(WORD_W);
                        end else begin
                           sh    <= sh << 1;
                           wbits <= wbits - WB_W'(1);
                        end
                     end
                  end
               end
            end
            ST_GAP: if (tick) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R9
   idle_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_n) |-> (sclk == cfg_cpol));

   // R13
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick && stall) |=> ($stable(sclk) && !ss_n));

   // R5
   xch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xch) |-> $rose(ss_n));

endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master #(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned FIFO_DEPTH = 64,
   parameter int unsigned LEN_W      = 12,
   parameter int unsigned DIV_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              cfg_multi,
   input  logic              cfg_auto,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              xch_set,
   output logic              xch,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              sclk,
   output logic              mosi,
   output logic              ss_n,
   output logic              busy,
   output logic              tx_done_irq,
   output logic              ovf
);
   generate
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("spi_burst_master: WORD_W must be a power of two");
      end
      if (LEN_W < $clog2(WORD_W)) begin : g_bad_len
         $error("spi_burst_master: LEN_W too narrow for WORD_W");
      end
   endgenerate

   logic [WORD_W-1:0] q_data;
   logic              q_empty, q_full, q_pop, run_en, tick;

   spi_txq #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(q_pop), .rd_data(q_data), .empty(q_empty), .full(q_full),
      .ovf(ovf)
   );

   spi_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(run_en), .div(cfg_div), .tick(tick)
   );

   spi_burst_eng #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_multi(cfg_multi),
      .cfg_auto(cfg_auto), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .xch_set(xch_set), .tick(tick), .q_data(q_data), .q_empty(q_empty),
      .q_pop(q_pop), .run_en(run_en), .sclk(sclk), .mosi(mosi),
      .ss_n(ss_n), .busy(busy), .xch(xch)
   );

   assign tx_done_irq = q_empty && !busy;

   // R6
   no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_n && !xch && !xch_set && !cfg_auto) |=> ss_n);

   // R12
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full && !q_pop) |=> q_full);

endmodule

// File: tb/spi_burst_master_bench.sv
`timescale 1ns/1ps
module spi_burst_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_len = '0;
   logic        cfg_multi = 1'b0, cfg_auto = 1'b0;
   logic [7:0]  cfg_div = '0;
   logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic        xch_set = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        xch, sclk, mosi, ss_n, busy, tx_done_irq, ovf;

   always #2.5 clk = ~clk;

   spi_burst_master u_spi_burst_master (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_multi(cfg_multi),
      .cfg_auto(cfg_auto), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .xch_set(xch_set), .xch(xch), .wr_en(wr_en),
      .wr_data(wr_data), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
      .busy(busy), .tx_done_irq(tx_done_irq), .ovf(ovf)
   );

   int          cyc = 0, checks = 0, errors = 0;
   logic        cap [0:8191];
   int          cap_n, bursts, ntog, t1, half_meas;
   int          bbits [0:15];
   logic        prev_sclk = 1'b0, prev_ss = 1'b1, mon_clr = 1'b0;
   logic [31:0] wq [0:127];
   logic [31:0] seed = 32'h1234_5678;

   always @(posedge clk) cyc <= cyc + 1;

   // serial monitor: samples at negedge, away from the active edge
   always @(negedge clk) begin
      if (mon_clr) begin
         cap_n = 0; bursts = 0; ntog = 0; t1 = 0; half_meas = 0;
         for (int i = 0; i < 16; i++) bbits[i] = 0;
      end else begin
         if (prev_ss && !ss_n) begin
            bursts = bursts + 1;
            ntog = 0;
         end
         if (!ss_n && sclk != prev_sclk) begin
            ntog = ntog + 1;
            if (ntog == 1) t1 = cyc;
            if (ntog == 2) half_meas = cyc - t1;
            if ((prev_sclk == cfg_cpol) != cfg_cpha) begin
               if (cap_n < 8192) cap[cap_n] = mosi;
               cap_n = cap_n + 1;
               if (bursts >= 1 && bursts <= 16) bbits[bursts-1] = bbits[bursts-1] + 1;
            end
         end
      end
      prev_sclk = sclk;
      prev_ss   = ss_n;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   function automatic logic exp_bit(input int len, input int i);
      int r = len % 32;
      if (r == 0) r = 32;
      if (i < r) return wq[0][r-1-i];
      return wq[(i-r)/32 + 1][31 - ((i-r) % 32)];
   endfunction

   task automatic clr_mon();
      @(negedge clk) mon_clr = 1'b1;
      @(negedge clk) mon_clr = 1'b0;
   endtask

   task automatic push(input logic [31:0] d);
      @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic kick();
      @(negedge clk) xch_set = 1'b1;
      @(negedge clk) xch_set = 1'b0;
   endtask

   task automatic wait_done(input int lim);
      int n = 0;
      while ((xch || busy) && n < lim) begin
         @(negedge clk);
         n++;
      end
      repeat (4 * (int'(cfg_div) + 1) + 4) @(negedge clk);
   endtask

   task automatic cmp_stream(input int len, input string req);
      int bad = 0;
      for (int i = 0; i < len; i++) if (cap[i] !== exp_bit(len, i)) bad++;
      check(cap_n == len, req, cap_n, len);
      check(bad == 0, req, bad, 0);
   endtask

   function automatic int len_of(input int idx);
      case (idx)
         0: return 1;
         1: return 9;
         2: return 31;
         3: return 32;
         4: return 33;
         5: return 64;
         default: return 100;
      endcase
   endfunction

   // watchdog
   initial begin
      wait (cyc >= 190000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      clr_mon();
      // reset state
      check(ss_n == 1'b1, "R11 reset ss_n", int'(ss_n), 1);
      check(busy == 1'b0, "R11 reset busy", int'(busy), 0);
      check(sclk == 1'b0, "R9 reset sclk", int'(sclk), 0);
      check(tx_done_irq == 1'b1, "R8 reset irq", int'(tx_done_irq), 1);
      check(ovf == 1'b0, "R12 reset ovf", int'(ovf), 0);
      check(xch == 1'b0, "R5 reset xch", int'(xch), 0);

      // sweep: polarity/phase x length x divider, single-burst exchange
      for (int m = 0; m < 4; m++) begin
         for (int li = 0; li < 7; li++) begin
            int len = len_of(li);
            int nw  = (len + 31) / 32;
            cfg_cpol  = m[1];
            cfg_cpha  = m[0];
            cfg_div   = 8'((m + li) % 3);
            cfg_len   = 12'(len - 1);
            cfg_multi = 1'b0;
            cfg_auto  = 1'b0;
            repeat (2) @(negedge clk);
            clr_mon();
            for (int k = 0; k < nw; k++) begin
               wq[k] = rnd();
               push(wq[k]);
            end
            kick();
            wait_done(5000);
            cmp_stream(len, "R1 R3 sweep");
            check(bursts == 1, "R5 sweep bursts", bursts, 1);
            check(half_meas == int'(cfg_div) + 1, "R10 half period", half_meas, int'(cfg_div) + 1);
            check(sclk == cfg_cpol, "R9 idle level", int'(sclk), int'(cfg_cpol));
            check(tx_done_irq == 1'b1, "R8 drained", int'(tx_done_irq), 1);
         end
      end

      // start strobe required, single-burst mode leaves words queued
      cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 8'd1; cfg_len = 12'd8;
      cfg_multi = 1'b0; cfg_auto = 1'b0;
      clr_mon();
      for (int k = 0; k < 3; k++) begin wq[k] = rnd(); push(wq[k]); end
      repeat (60) @(negedge clk);
      check(bursts == 0, "R6 no strobe no burst", bursts, 0);
      check(ss_n == 1'b1, "R6 ss idle", int'(ss_n), 1);
      check(tx_done_irq == 1'b0, "R8 words queued", int'(tx_done_irq), 0);
      kick();
      wait_done(5000);
      repeat (100) @(negedge clk);
      check(bursts == 1, "R5 one burst only", bursts, 1);
      cmp_stream(9, "R5 first word");
      check(xch == 1'b0, "R5 xch cleared", int'(xch), 0);
      check(tx_done_irq == 1'b0, "R8 entries remain", int'(tx_done_irq), 0);
      for (int k = 1; k < 3; k++) begin
         wq[0] = wq[k];
         clr_mon();
         kick();
         wait_done(5000);
         cmp_stream(9, "R5 next word");
      end
      check(tx_done_irq == 1'b1, "R8 after flush", int'(tx_done_irq), 1);

      // per-burst chip-select mode drains the queue
      cfg_multi = 1'b1;
      clr_mon();
      for (int k = 0; k < 3; k++) begin wq[k] = rnd(); push(wq[k]); end
      kick();
      wait_done(5000);
      check(bursts == 3, "R4 burst count", bursts, 3);
      for (int b = 0; b < 3; b++) check(bbits[b] == 9, "R4 burst bits", bbits[b], 9);
      begin
         int bad = 0;
         for (int i = 0; i < 27; i++) if (cap[i] !== wq[i/9][8 - (i%9)]) bad++;
         check(bad == 0, "R4 stream", bad, 0);
      end
      check(xch == 1'b0, "R4 xch cleared", int'(xch), 0);
      check(tx_done_irq == 1'b1, "R8 drained multi", int'(tx_done_irq), 1);

      // auto start ignores the waveform bit
      cfg_multi = 1'b0; cfg_auto = 1'b1; cfg_len = 12'd11;
      clr_mon();
      for (int k = 0; k < 2; k++) begin wq[k] = rnd(); push(wq[k]); end
      begin
         int n = 0;
         repeat (4) @(negedge clk);
         while (!(tx_done_irq && !busy) && n < 5000) begin @(negedge clk); n++; end
         repeat (12) @(negedge clk);
      end
      check(bursts == 2, "R7 auto bursts", bursts, 2);
      check(bbits[0] == 12 && bbits[1] == 12, "R7 auto bits", bbits[1], 12);
      begin
         int bad = 0;
         for (int i = 0; i < 24; i++) if (cap[i] !== wq[i/12][11 - (i%12)]) bad++;
         check(bad == 0, "R7 auto stream", bad, 0);
      end
      cfg_auto = 1'b0;

      // queue runs dry mid-burst
      cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 8'd1; cfg_len = 12'd63;
      repeat (2) @(negedge clk);
      clr_mon();
      wq[0] = rnd(); wq[1] = rnd();
      push(wq[0]);
      kick();
      repeat (400) @(negedge clk);
      check(ss_n == 1'b0, "R13 ss held", int'(ss_n), 0);
      check(busy == 1'b1, "R11 busy during stall", int'(busy), 1);
      check(cap_n == 32, "R13 bits before stall", cap_n, 32);
      check(sclk == 1'b0, "R13 sclk frozen", int'(sclk), 0);
      push(wq[1]);
      wait_done(5000);
      cmp_stream(64, "R13 resumed");
      check(busy == 1'b0, "R11 busy released", int'(busy), 0);

      // 4096-bit burst with refill
      cfg_cpha = 1'b0; cfg_div = 8'd0; cfg_len = 12'd4095;
      repeat (2) @(negedge clk);
      clr_mon();
      for (int k = 0; k < 128; k++) wq[k] = rnd();
      for (int k = 0; k < 64; k++) push(wq[k]);
      kick();
      for (int k = 64; k < 128; k++) begin
         repeat (70) @(negedge clk);
         push(wq[k]);
      end
      wait_done(20000);
      cmp_stream(4096, "R2 long burst");
      check(bursts == 1, "R2 one burst", bursts, 1);
      check(ovf == 1'b0, "R12 no spurious ovf", int'(ovf), 0);

      // overflow: 65 writes into 64 entries
      cfg_len = 12'd2047;
      clr_mon();
      for (int k = 0; k < 65; k++) begin wq[k] = rnd(); push(wq[k]); end
      check(ovf == 1'b1, "R12 ovf set", int'(ovf), 1);
      kick();
      wait_done(20000);
      cmp_stream(2048, "R12 dropped write");
      check(tx_done_irq == 1'b1, "R12 queue empty after 64", int'(tx_done_irq), 1);
      check(ovf == 1'b1, "R12 ovf sticky", int'(ovf), 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule